// File: doc/BRIEF.md
# ADC Parallel Conversion Controller

This block sits on the host side of a successive-approximation converter that has a parallel data bus. It issues conversion-start pulses either from its own free-running interval timer or when the host writes to the block. It then follows the converter's busy line. When busy drops, the block raises an interrupt request that stays high until the host has taken the result. The converter itself is outside the block.

The host reaches the result through a single-request, single-acknowledge bus port. In wide mode one read returns the 12-bit sample right-justified in a 16-bit word. In byte mode the host fetches the result as two byte accesses, and the bus address bit steers the converter's high-byte-enable line. The first byte access (address bit 0 low) starts a conversion itself and is held with wait states until the converter finishes. The second access is served at once and returns the whole sample, with the high nibble placed above the saved low byte.

A read that would take the result while a conversion is running is refused and flagged. A start request that arrives while a conversion is running is dropped and flagged.

Top module: `adc_par_ctrl`

## Requirements
- R1: With `timer_en` high and the converter idle, `adc_convst` rises once every `TIMER_DIV` cycles, and each pulse is exactly `CONVST_W` cycles wide.
- R2: A host write (`bus_req` with `bus_we` high) starts a conversion when idle and is acknowledged on the cycle after the request is seen; `bus_ack` is a single-cycle pulse.
- R3: `irq` goes high on the cycle after `adc_busy` is seen low at the end of a conversion. It stays high until a wide-mode read, or a byte-mode read at address 1, pulses `adc_rd`; a byte read at address 0 leaves it set.
- R4: A wide-mode read, or a byte-mode read at address 1, made while a conversion is running does not pulse `adc_rd`. It is acknowledged on the next cycle with data 0 and sets the sticky `rd_err`.
- R5: A start request (timer tick or host write) that arrives while a conversion is running issues no new `adc_convst` pulse and sets the sticky `overrun`.
- R6: A wide-mode read with the converter idle pulses `adc_rd` for one cycle and is acknowledged two cycles after the request, with `bus_rdata = {4'b0, adc_db}`.
- R7: `adc_wide` is the inverse of `byte_mode`; `adc_hben` equals `bus_addr` in byte mode and is 0 in wide mode.
- R8: In byte mode, a read at address 0 starts a conversion if none is running, or joins the one that is running. It is held with wait states until that conversion ends, then returns `{8'h00, low byte}`.
- R9: In byte mode, a read at address 1 made while idle has no wait state: it is acknowledged two cycles after the request and returns `{4'b0, high nibble, saved low byte}`.
- R10: The top four bits of `bus_rdata` are zero whenever `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 selects the 8-bit two-access result path |
| timer_en | input | 1 | Enables the interval timer as a start source |
| bus_req | input | 1 | Host access request, held until acknowledged |
| bus_we | input | 1 | 1 = write (start conversion), 0 = read |
| bus_addr | input | 1 | Byte select in byte mode (0 first, 1 second) |
| bus_ack | output | 1 | Single-cycle access acknowledge |
| bus_rdata | output | 16 | Read data, valid with `bus_ack` |
| adc_convst | output | 1 | Conversion start pulse to the converter |
| adc_rd | output | 1 | Read strobe to the converter |
| adc_hben | output | 1 | High-byte enable to the converter |
| adc_wide | output | 1 | Width select to the converter, low in byte mode |
| adc_busy | input | 1 | Converter busy, synchronous to `clk` |
| adc_db | input | 12 | Converter data bus |
| irq | output | 1 | End-of-conversion interrupt request |
| overrun | output | 1 | Sticky: a start was dropped during a conversion |
| rd_err | output | 1 | Sticky: a result read was refused during a conversion |

## Verification
The assertions assume that `adc_busy` is synchronous to `clk`, rises only after an `adc_convst` pulse, and falls within a bounded time. They also assume that the host holds `bus_req` steady until `bus_ack` and drops it on the cycle of the acknowledge. The bench's converter model follows these rules. It raises busy only on a start pulse it has seen and keeps it high for a fixed ten cycles. Its bus tasks change requests only on falling clock edges and release them when the acknowledge is seen. Timer runs are kept long enough that every tick finds the converter idle.

// File: rtl/adc_par_ctrl.sv
module adc_par_ctrl #(
  parameter int DATA_W    = 12,
  parameter int BUS_W     = 16,
  parameter int TIMER_DIV = 64,
  parameter int CONVST_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              timer_en,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_addr,
  output logic              bus_ack,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              adc_convst,
  output logic              adc_rd,
  output logic              adc_hben,
  output logic              adc_wide,
  input  logic              adc_busy,
  input  logic [DATA_W-1:0] adc_db,
  output logic              irq,
  output logic              overrun,
  output logic              rd_err
);

  localparam int TW   = (TIMER_DIV > 1) ? $clog2(TIMER_DIV) : 1;
  localparam int PW   = $clog2(CONVST_W + 1);
  localparam int LO_W = 8;
  localparam int HI_W = DATA_W - LO_W;
  localparam int PADW = BUS_W - DATA_W;

  typedef enum logic [1:0] {C_IDLE, C_PULSE, C_WHI, C_WLO} cst_t;
  typedef enum logic [1:0] {B_IDLE, B_WAIT, B_RD, B_ACK} bst_t;

  cst_t              cs;
  bst_t              bs;
  logic [TW-1:0]     tcnt;
  logic [PW-1:0]     pcnt;
  logic [LO_W-1:0]   lo_q;
  logic [BUS_W-1:0]  rbuf;

  logic tmr_tick, acc, lead_rd, conv_idle, wr_start, brd_start, start_any, eoc, bad_rd, consume;

  assign conv_idle = (cs == C_IDLE);
  assign tmr_tick  = timer_en && (tcnt == TW'(TIMER_DIV - 1));
  assign acc       = (bs == B_IDLE) && bus_req;
  assign lead_rd   = byte_mode && !bus_addr;
  assign wr_start  = acc && bus_we;
  assign brd_start = acc && !bus_we && lead_rd && conv_idle;
  assign start_any = tmr_tick || wr_start || brd_start;
  assign bad_rd    = acc && !bus_we && !lead_rd && !conv_idle;
  assign eoc       = (cs == C_WLO) && !adc_busy;
  assign consume   = (bs == B_RD) && (!byte_mode || bus_addr);

  assign adc_convst = (cs == C_PULSE);
  assign adc_rd     = (bs == B_RD);
  assign bus_ack    = (bs == B_ACK);
  assign bus_rdata  = rbuf;
  assign adc_wide   = !byte_mode;
  assign adc_hben   = byte_mode && bus_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             tcnt <= '0;
    else if (!timer_en)     tcnt <= '0;
    else if (tmr_tick)      tcnt <= '0;
    else                    tcnt <= tcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs   <= C_IDLE;
      pcnt <= '0;
    end else begin
      case (cs)
        C_IDLE:  if (start_any) begin cs <= C_PULSE; pcnt <= '0; end
        C_PULSE: if (pcnt == PW'(CONVST_W - 1)) cs <= C_WHI;
                 else pcnt <= pcnt + 1'b1;
        C_WHI:   if (adc_busy) cs <= C_WLO;
        C_WLO:   if (!adc_busy) cs <= C_IDLE;
        default: cs <= C_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bs <= B_IDLE;
    else begin
      case (bs)
        B_IDLE: if (bus_req) begin
                  if (bus_we)              bs <= B_ACK;
                  else if (lead_rd)        bs <= B_WAIT;
                  else if (!conv_idle)     bs <= B_ACK;
                  else if (tmr_tick)       bs <= B_WAIT;
                  else                     bs <= B_RD;
                end
        B_WAIT: if (conv_idle && !tmr_tick) bs <= B_RD;
        B_RD:   bs <= B_ACK;
        B_ACK:  bs <= B_IDLE;
        default: bs <= B_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rbuf <= '0;
      lo_q <= '0;
    end else if (acc && (bus_we || bad_rd)) begin
      rbuf <= '0;
    end else if (bs == B_RD) begin
      if (!byte_mode)
        rbuf <= {{PADW{1'b0}}, adc_db};
      else if (!bus_addr) begin
        lo_q <= adc_db[LO_W-1:0];
        rbuf <= {{(BUS_W-LO_W){1'b0}}, adc_db[LO_W-1:0]};
      end else
        rbuf <= {{PADW{1'b0}}, adc_db[HI_W-1:0], lo_q};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq     <= 1'b0;
      overrun <= 1'b0;
      rd_err  <= 1'b0;
    end else begin
      if (eoc)          irq <= 1'b1;
      else if (consume) irq <= 1'b0;
      if (start_any && !conv_idle) overrun <= 1'b1;
      if (bad_rd)                  rd_err  <= 1'b1;
    end

  AST_RD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_rd |-> (cs == C_IDLE) && !adc_busy); // R4
  AST_IRQ_SET_AT_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cs == C_WLO) && !$past(adc_busy)); // R3
  AST_IRQ_CLR_BY_RD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(adc_rd)); // R3
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> rd_err); // R4
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack); // R2
  AST_CONVST_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_convst) |-> $past(cs == C_IDLE)); // R5
  AST_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> (bus_rdata[BUS_W-1:DATA_W] == '0)); // R10

endmodule

// File: tb/adc_par_ctrl_test.sv
`timescale 1ns/1ps
module adc_par_ctrl_test;
  localparam int TDIV = 64;
  localparam int CW   = 2;
  localparam int CONV = 10;

  logic clk = 0, rst_n = 0;
  logic byte_mode = 0, timer_en = 0, bus_req = 0, bus_we = 0, bus_addr = 0;
  logic bus_ack, adc_convst, adc_rd, adc_hben, adc_wide, irq, overrun, rd_err;
  logic [15:0] bus_rdata;
  logic adc_busy = 0;
  logic [11:0] adc_db;
  logic [11:0] conv_word = 12'h000, smp = 12'hA5C;

  int checks = 0, errors = 0, cyc = 0, rd_cnt = 0, rise_cnt = 0, hi_len = 0, ccnt = 0;
  int rise_t[$];
  logic exp_irq = 0, prev_busy = 0, prev_cv = 0;

  adc_par_ctrl #(.DATA_W(12), .BUS_W(16), .TIMER_DIV(TDIV), .CONVST_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .timer_en(timer_en),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .adc_convst(adc_convst), .adc_rd(adc_rd), .adc_hben(adc_hben),
    .adc_wide(adc_wide), .adc_busy(adc_busy), .adc_db(adc_db), .irq(irq),
    .overrun(overrun), .rd_err(rd_err));

  always #10 clk = ~clk;

  assign adc_db = !byte_mode ? conv_word :
                  adc_hben   ? {8'h00, conv_word[11:8]} : {4'h0, conv_word[7:0]};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (adc_busy) begin
      ccnt--;
      if (ccnt == 0) begin adc_busy = 0; conv_word = smp; smp = smp + 12'h29B; end
    end else if (adc_convst) begin
      adc_busy = 1; ccnt = CONV;
    end
  end

  always @(negedge clk) begin
    if (adc_rd) rd_cnt++;
    if (adc_convst && !prev_cv) begin rise_cnt++; rise_t.push_back(cyc); end
    if (adc_convst) hi_len++;
    else if (hi_len > 0) begin
      chk(hi_len == CW, "R1 convst width", hi_len, CW);
      hi_len = 0;
    end
    prev_cv = adc_convst;
  end

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) exp_irq = 0;
    else if (prev_busy && !adc_busy) exp_irq = 1;
    else if (adc_rd && (!byte_mode || bus_addr)) exp_irq = 0;
    prev_busy = adc_busy;
    #5;
    if (rst_n) begin
      chk(irq == exp_irq, "R3 irq model", irq, exp_irq);
      chk(adc_wide == !byte_mode && adc_hben == (byte_mode && bus_addr), "R7 width/hben",
          {adc_wide, adc_hben}, {!byte_mode, byte_mode && bus_addr});
    end
  end

  task automatic bus_rd(input logic a, output logic [15:0] d, output int lat, output int rds);
    int r0;
    @(negedge clk);
    r0 = rd_cnt; bus_req = 1; bus_we = 0; bus_addr = a; lat = 0;
    do begin @(negedge clk); lat++; end while (!bus_ack && lat < 2000);
    d = bus_rdata; bus_req = 0; rds = rd_cnt - r0;
  endtask

  task automatic bus_wr(output int lat);
    @(negedge clk);
    bus_req = 1; bus_we = 1; lat = 0;
    do begin @(negedge clk); lat++; end while (!bus_ack && lat < 2000);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (adc_busy || adc_convst) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    logic [15:0] d;
    int lat, rds, r0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(irq == 0, "R3 reset irq", irq, 0);
    chk(overrun == 0, "R5 reset overrun", overrun, 0);
    chk(rd_err == 0, "R4 reset rd_err", rd_err, 0);
    chk(adc_convst == 0 && bus_ack == 0, "R2 reset outputs", {adc_convst, bus_ack}, 0);
    chk(adc_wide == 1, "R7 reset wide", adc_wide, 1);

    // R2: write start
    bus_wr(lat);
    chk(lat == 1, "R2 write ack latency", lat, 1);
    chk(rise_cnt == 1 || adc_convst, "R2 convst issued", rise_cnt, 1);
    // R4: read during conversion
    bus_rd(0, d, lat, rds);
    chk(lat == 1 && d == 0, "R4 refused read", {lat[15:0], d}, {16'd1, 16'd0});
    chk(rds == 0, "R4 no adc_rd", rds, 0);
    chk(rd_err == 1, "R4 rd_err set", rd_err, 1);
    // R5: start during conversion
    chk(overrun == 0, "R5 overrun clear before", overrun, 0);
    bus_wr(lat);
    chk(overrun == 1, "R5 overrun set", overrun, 1);
    wait_idle();
    chk(rise_cnt == 1, "R5 no extra convst", rise_cnt, 1);
    // R3: irq holds
    repeat (20) @(negedge clk);
    chk(irq == 1, "R3 irq held", irq, 1);
    // R6/R10: word read
    bus_rd(0, d, lat, rds);
    chk(d == {4'h0, conv_word}, "R6 word data", d, {4'h0, conv_word});
    chk(lat == 2 && rds == 1, "R6 word latency", {lat[15:0], rds[15:0]}, {16'd2, 16'd1});
    chk(d[15:12] == 0, "R10 top nibble", d[15:12], 0);
    @(negedge clk);
    chk(irq == 0, "R3 irq cleared", irq, 0);

    // R8/R9: byte mode, first access starts conversion
    @(negedge clk) byte_mode = 1;
    r0 = rise_cnt;
    bus_rd(0, d, lat, rds);
    chk(rise_cnt == r0 + 1, "R8 byte read started conversion", rise_cnt, r0 + 1);
    chk(lat > CONV, "R8 wait states inserted", lat, CONV);
    chk(d == {8'h00, conv_word[7:0]}, "R8 low byte", d, {8'h00, conv_word[7:0]});
    chk(irq == 1, "R3 irq kept after first byte", irq, 1);
    bus_rd(1, d, lat, rds);
    chk(lat == 2, "R9 no wait on second byte", lat, 2);
    chk(d == {4'h0, conv_word}, "R9 reassembled word", d, {4'h0, conv_word});
    @(negedge clk);
    chk(irq == 0, "R3 irq cleared by second byte", irq, 0);

    // R4/R8: byte reads while a write-started conversion runs
    r0 = rise_cnt;
    bus_wr(lat);
    bus_rd(1, d, lat, rds);
    chk(lat == 1 && d == 0 && rds == 0, "R4 second byte refused", {lat[15:0], d}, {16'd1, 16'd0});
    bus_rd(0, d, lat, rds);
    chk(rise_cnt == r0 + 1, "R8 joined running conversion", rise_cnt, r0 + 1);
    chk(d == {8'h00, conv_word[7:0]}, "R8 low byte joined", d, {8'h00, conv_word[7:0]});
    bus_rd(1, d, lat, rds);
    chk(d == {4'h0, conv_word} && lat == 2, "R9 word after join", d, {4'h0, conv_word});

    // R1: timer
    @(negedge clk) begin byte_mode = 0; timer_en = 1; end
    rise_t.delete();
    while (rise_t.size() < 3) @(negedge clk);
    chk(rise_t[1] - rise_t[0] == TDIV, "R1 timer interval", rise_t[1] - rise_t[0], TDIV);
    chk(rise_t[2] - rise_t[1] == TDIV, "R1 timer interval", rise_t[2] - rise_t[1], TDIV);
    @(negedge clk) timer_en = 0;
    wait_idle();
    bus_rd(0, d, lat, rds);
    chk(d == {4'h0, conv_word}, "R6 word after timer", d, {4'h0, conv_word});
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule